// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a small, fully associative translation buffer that turns a 32-bit virtual address into a 32-bit physical address. Every slot has a tag word and a data word. The tag word holds a virtual tag, a page-size code, a valid flag and a preserved flag. The data word holds a physical base, a big-endian flag, an element-size code and a mixed-attribute flag. Each slot carries its own page size, chosen from 4 KB, 64 KB, 1 MB and 16 MB. As a result, every slot compares the incoming address under its own mask. All slots are compared in the same cycle. The result is one of three outcomes: a hit, a miss, or a multi-hit.

Software reaches the block through a write port. Each write carries a 3-bit register select and a 32-bit data word. The tag and data words of the slot at the victim index can be read back at any time. A lock-base index keeps preserved slots below the replacement window. A miss or a multi-hit sets a sticky status bit. If the matching enable bit is set, the block also latches the faulting address and switches translation off until software turns it on again. Three external event inputs set the remaining status bits.

Top module: `xlat_buffer`

## Requirements
- R1: A write with select 0 stages a tag word; a following write with select 1 stores the staged tag, with valid (bit 2) forced to 1, and the data word into the slot at `victim_idx`. Tag keeps bits [31:12], [3:0] (bit 3 preserved, bits [1:0] page size); data keeps bits [31:12] base, bit 9 big-endian, bits [8:7] element size, bit 6 mixed. All other bits read back as 0. `rd_tag`/`rd_data` always show the slot at `victim_idx`.
- R2: After each store, `victim_idx` advances by one. From the last slot it wraps to `lock_base`. Select 2 writes `lock_base` and select 3 writes `victim_idx`, both from the low data bits.
- R3: Page-size code 0/1/2/3 gives the virtual compare mask 0xFFFFF000/0xFFFF0000/0xFFF00000/0xFF000000. On a hit, `res_paddr` is (base AND mask) OR (vaddr AND NOT mask), with the slot's attributes. All results appear with `res_valid` one cycle after `lk_valid`.
- R4: Every valid slot compares under its own page mask, so slots of different page sizes can coexist.
- R5: A lookup matching no valid slot asserts `res_miss` and sets status bit 0.
- R6: A lookup matching more than one valid slot asserts `res_multi`, with `res_hit` low and `res_paddr` and the attributes zero, and sets status bit 4. Hit, miss and multi are mutually exclusive.
- R7: When a miss or multi-hit sets a status bit whose enable bit is 1, `fault_addr` takes the lookup address and `xlat_en` drops to 0. If the enable bit is 0, both stay unchanged. A fault wins over a same-cycle enable write.
- R8: While `xlat_en` is 0, a lookup returns `res_paddr` equal to the virtual address, with hit, miss and multi all low, and changes no status bit.
- R9: Writing select 5 clears the status bits written as 1. A bit set in the same cycle stays set. Select 4 writes the 5-bit enable and select 6 bit 0 writes `xlat_en`.
- R10: `evt_xlat`, `evt_emu` and `evt_walk` set status bits 1, 2 and 3. `irq` is high while any status bit and its enable bit are both 1.
- R11: A write with select 7 clears the valid bit of every slot whose preserved bit is 0; preserved slots keep hitting.
- R12: `revision` shows the major version in bits [7:4] and the minor version in bits [3:0].
- R13: After reset, all slots are invalid, and status, enable, indices, `fault_addr`, `xlat_en` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select (0 tag, 1 data, 2 lock, 3 victim, 4 enable, 5 clear, 6 control, 7 flush) |
| cfg_wr_data | input | 32 | Register write data |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| evt_walk | input | 1 | Table-walk fault event |
| evt_emu | input | 1 | Emulator miss event |
| evt_xlat | input | 1 | Translation fault event |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Exactly one slot matched |
| res_miss | output | 1 | No slot matched |
| res_multi | output | 1 | Several slots matched |
| res_paddr | output | 32 | Translated (or bypassed) address |
| res_big_endian | output | 1 | Hit slot's endianness flag |
| res_elsz | output | 2 | Hit slot's element-size code |
| res_mixed | output | 1 | Hit slot's mixed-attribute flag |
| rd_tag | output | 32 | Tag word of slot at victim index |
| rd_data | output | 32 | Data word of slot at victim index |
| lock_base | output | IDX_W | Lock-base index |
| victim_idx | output | IDX_W | Victim index |
| irq_status | output | 5 | Sticky status bits |
| irq_enable | output | 5 | Interrupt enable bits |
| fault_addr | output | 32 | Last faulting virtual address |
| xlat_en | output | 1 | Translation enabled |
| irq | output | 1 | Interrupt request |
| revision | output | 8 | Major and minor version |

## Verification
Two actions can land on the same status bit in the same clock: a lookup that raises a status bit, and a software write-one-to-clear of that bit. The bench provokes this in two ways. A directed cycle pairs a miss with a clear of bit 0. The random phase also pairs clear writes of random bit patterns with lookups. The bench model applies the clear first and the new event second, so the outcome is judged against "set wins". A second collision is checked the same way: a multi-hit fault arriving while translation is disabled and re-enabled around it. Here the model expects `xlat_en` low and `fault_addr` holding the lookup address.

// File: rtl/xlat_pkg.sv
// Shared encodings, field positions and helpers for the translation buffer.
// Assumes a 32-bit virtual and physical address space with pages of at least 4 KB.
package xlat_pkg;

    localparam int VA_W = 32;
    localparam int ST_W = 5;

    // Register select codes on the write port
    localparam logic [2:0] SEL_TAG    = 3'd0;
    localparam logic [2:0] SEL_DATA   = 3'd1;
    localparam logic [2:0] SEL_LOCK   = 3'd2;
    localparam logic [2:0] SEL_VICTIM = 3'd3;
    localparam logic [2:0] SEL_IRQEN  = 3'd4;
    localparam logic [2:0] SEL_STATUS = 3'd5;
    localparam logic [2:0] SEL_CTRL   = 3'd6;
    localparam logic [2:0] SEL_FLUSH  = 3'd7;

    // Status bit positions
    localparam int ST_TLBMISS = 0;
    localparam int ST_XLATF   = 1;
    localparam int ST_EMUMISS = 2;
    localparam int ST_WALKF   = 3;
    localparam int ST_MULTI   = 4;

    // Tag and data word field positions
    localparam int TAG_VALID = 2;
    localparam int TAG_PRSV  = 3;
    localparam int DATA_BE   = 9;
    localparam int DATA_ES_H = 8;
    localparam int DATA_ES_L = 7;
    localparam int DATA_MIX  = 6;
    localparam logic [VA_W-1:0] TAG_KEEP  = 32'hFFFF_F00F;
    localparam logic [VA_W-1:0] DATA_KEEP = 32'hFFFF_F3C0;
    localparam int MIN_PAGE_BITS = 12;
    localparam int PAGE_STEP     = 4;

    // Outcome of one lookup
    typedef struct packed {
        logic            hit;
        logic            miss;
        logic            multi;
        logic [VA_W-1:0] paddr;
        logic            be;
        logic [1:0]      elsz;
        logic            mixed;
    } lk_res_t;

    // Compare mask for a page-size code: 12, 16, 20 or 24 offset bits
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] psz);
        return {VA_W{1'b1}} << (MIN_PAGE_BITS + PAGE_STEP * int'(psz));
    endfunction

endpackage

// File: rtl/xlat_entry_store.sv
// Slot storage for the translation buffer: staged tag, slot arrays,
// lock-base and victim indices, global invalidate and victim read-back.
// Assumes one register write per cycle; N_ENTRIES is a power of two.
module xlat_entry_store
    import xlat_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_wr_sel,
    input  logic [VA_W-1:0]  cfg_wr_data,
    output logic [VA_W-1:0]  tag_q  [N_ENTRIES],
    output logic [VA_W-1:0]  data_q [N_ENTRIES],
    output logic [IDX_W-1:0] lock_q,
    output logic [IDX_W-1:0] victim_q,
    output logic [VA_W-1:0]  rd_tag,
    output logic [VA_W-1:0]  rd_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ENTRIES - 1);

    logic [VA_W-1:0] pend_tag_q;
    logic            do_tag, do_load, do_lock, do_victim, do_flush;

    // Decode the write strobes this unit owns
    always_comb begin
        do_tag    = cfg_wr_en && (cfg_wr_sel == SEL_TAG);
        do_load   = cfg_wr_en && (cfg_wr_sel == SEL_DATA);
        do_lock   = cfg_wr_en && (cfg_wr_sel == SEL_LOCK);
        do_victim = cfg_wr_en && (cfg_wr_sel == SEL_VICTIM);
        do_flush  = cfg_wr_en && (cfg_wr_sel == SEL_FLUSH);
    end

    // Stage the tag word with the valid flag forced on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag_q <= '0;
        end else if (do_tag) begin
            pend_tag_q <= (cfg_wr_data & TAG_KEEP) | (VA_W'(1) << TAG_VALID);
        end
    end

    // Update slots: store at victim on a data write, drop non-preserved on flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENTRIES; e++) begin
                tag_q[e]  <= '0;
                data_q[e] <= '0;
            end
        end else begin
            for (int e = 0; e < N_ENTRIES; e++) begin
                if (do_load && (victim_q == IDX_W'(e))) begin
                    tag_q[e]  <= pend_tag_q;
                    data_q[e] <= cfg_wr_data & DATA_KEEP;
                end else if (do_flush && !tag_q[e][TAG_PRSV]) begin
                    tag_q[e][TAG_VALID] <= 1'b0;
                end
            end
        end
    end

    // Maintain lock base and victim; victim wraps to the lock base after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= '0;
            victim_q <= '0;
        end else begin
            if (do_lock) begin
                lock_q <= cfg_wr_data[IDX_W-1:0];
            end
            if (do_victim) begin
                victim_q <= cfg_wr_data[IDX_W-1:0];
            end else if (do_load) begin
                victim_q <= (victim_q == LAST_IDX) ? lock_q : victim_q + 1'b1;
            end
        end
    end

    // Present the victim slot for read-back
    always_comb begin
        rd_tag  = tag_q[victim_q];
        rd_data = data_q[victim_q];
    end

endmodule

// File: rtl/xlat_match.sv
// Parallel compare of one virtual address against every slot, each under the
// mask of its own page size, and assembly of hit, miss or multi-hit.
// Assumes tags hold zeros below bit 12 except the flag and size fields.
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic [VA_W-1:0] tag_q  [N_ENTRIES],
    input  logic [VA_W-1:0] data_q [N_ENTRIES],
    output lk_res_t         res
);

    logic [N_ENTRIES-1:0] hit_vec;
    logic [VA_W-1:0]      mask_v [N_ENTRIES];
    logic [VA_W-1:0]      sel_mask, sel_data;
    int                   n_hit;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        assign mask_v[e]  = page_mask(tag_q[e][1:0]);
        assign hit_vec[e] = tag_q[e][TAG_VALID] &&
                            (((lk_vaddr ^ tag_q[e]) & mask_v[e]) == '0);
    end

    // Merge mask and data of the matching slots
    always_comb begin
        sel_mask = '0;
        sel_data = '0;
        for (int e = 0; e < N_ENTRIES; e++) begin
            if (hit_vec[e]) begin
                sel_mask = sel_mask | mask_v[e];
                sel_data = sel_data | data_q[e];
            end
        end
    end

    // Classify the lookup and form the translated address
    always_comb begin
        n_hit     = $countones(hit_vec);
        res       = '0;
        res.hit   = (n_hit == 1);
        res.miss  = (n_hit == 0);
        res.multi = (n_hit > 1);
        if (n_hit == 1) begin
            res.paddr = (sel_data & sel_mask) | (lk_vaddr & ~sel_mask);
            res.be    = sel_data[DATA_BE];
            res.elsz  = sel_data[DATA_ES_H:DATA_ES_L];
            res.mixed = sel_data[DATA_MIX];
        end
    end

endmodule

// File: rtl/xlat_fault_ctrl.sv
// Sticky status, interrupt enable, fault address capture and translation enable.
// Assumes lookup outcome inputs are the combinational result of the current request.
module xlat_fault_ctrl
    import xlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_fire,
    input  logic [VA_W-1:0] lk_vaddr,
    input  logic            lk_miss,
    input  logic            lk_multi,
    input  logic            evt_walk,
    input  logic            evt_emu,
    input  logic            evt_xlat,
    input  logic            wr_status,
    input  logic            wr_irqen,
    input  logic            wr_ctrl,
    input  logic [ST_W-1:0] wr_bits,
    output logic [ST_W-1:0] status_q,
    output logic [ST_W-1:0] irqen_q,
    output logic [VA_W-1:0] fault_addr_q,
    output logic            xlat_en_q,
    output logic            irq
);

    logic [ST_W-1:0] set_vec, clr_vec;
    logic            fault_take;

    // Gather new events and clears for this cycle
    always_comb begin
        set_vec              = '0;
        set_vec[ST_TLBMISS]  = lk_fire && lk_miss;
        set_vec[ST_MULTI]    = lk_fire && lk_multi;
        set_vec[ST_XLATF]    = evt_xlat;
        set_vec[ST_EMUMISS]  = evt_emu;
        set_vec[ST_WALKF]    = evt_walk;
        clr_vec              = wr_status ? wr_bits : '0;
        fault_take           = (set_vec[ST_TLBMISS] && irqen_q[ST_TLBMISS]) ||
                               (set_vec[ST_MULTI]   && irqen_q[ST_MULTI]);
    end

    // Status bits: clear by writing ones, a same-cycle event wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | set_vec;
        end
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irqen_q <= '0;
        end else if (wr_irqen) begin
            irqen_q <= wr_bits;
        end
    end

    // Capture fault address and drop translation on an enabled lookup fault
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_addr_q <= '0;
            xlat_en_q    <= 1'b0;
        end else if (fault_take) begin
            fault_addr_q <= lk_vaddr;
            xlat_en_q    <= 1'b0;
        end else if (wr_ctrl) begin
            xlat_en_q    <= wr_bits[0];
        end
    end

    // Interrupt request from enabled status bits
    assign irq = |(status_q & irqen_q);

endmodule

// File: rtl/xlat_buffer.sv
// Top of the multi-page-size translation buffer: slot storage, parallel
// matcher, fault control and the one-cycle result register.
// Assumes synchronous active-low reset and one register write per cycle.
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int REV_MAJOR = 1,
    parameter int REV_MINOR = 2,
    localparam int IDX_W = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [2:0]       cfg_wr_sel,
    input  logic [31:0]      cfg_wr_data,
    input  logic             lk_valid,
    input  logic [31:0]      lk_vaddr,
    input  logic             evt_walk,
    input  logic             evt_emu,
    input  logic             evt_xlat,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_multi,
    output logic [31:0]      res_paddr,
    output logic             res_big_endian,
    output logic [1:0]       res_elsz,
    output logic             res_mixed,
    output logic [31:0]      rd_tag,
    output logic [31:0]      rd_data,
    output logic [IDX_W-1:0] lock_base,
    output logic [IDX_W-1:0] victim_idx,
    output logic [4:0]       irq_status,
    output logic [4:0]       irq_enable,
    output logic [31:0]      fault_addr,
    output logic             xlat_en,
    output logic             irq,
    output logic [7:0]       revision
);

    logic [VA_W-1:0] tag_q  [N_ENTRIES];
    logic [VA_W-1:0] data_q [N_ENTRIES];
    lk_res_t         match_res, bypass_res, res_q;

    xlat_entry_store #(.N_ENTRIES(N_ENTRIES)) i_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .cfg_wr_data (cfg_wr_data),
        .tag_q       (tag_q),
        .data_q      (data_q),
        .lock_q      (lock_base),
        .victim_q    (victim_idx),
        .rd_tag      (rd_tag),
        .rd_data     (rd_data)
    );

    xlat_match #(.N_ENTRIES(N_ENTRIES)) i_match (
        .lk_vaddr (lk_vaddr),
        .tag_q    (tag_q),
        .data_q   (data_q),
        .res      (match_res)
    );

    xlat_fault_ctrl i_fault (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_fire      (lk_valid && xlat_en),
        .lk_vaddr     (lk_vaddr),
        .lk_miss      (match_res.miss),
        .lk_multi     (match_res.multi),
        .evt_walk     (evt_walk),
        .evt_emu      (evt_emu),
        .evt_xlat     (evt_xlat),
        .wr_status    (cfg_wr_en && (cfg_wr_sel == SEL_STATUS)),
        .wr_irqen     (cfg_wr_en && (cfg_wr_sel == SEL_IRQEN)),
        .wr_ctrl      (cfg_wr_en && (cfg_wr_sel == SEL_CTRL)),
        .wr_bits      (cfg_wr_data[ST_W-1:0]),
        .status_q     (irq_status),
        .irqen_q      (irq_enable),
        .fault_addr_q (fault_addr),
        .xlat_en_q    (xlat_en),
        .irq          (irq)
    );

    // Pass-through outcome used while translation is off
    always_comb begin
        bypass_res       = '0;
        bypass_res.paddr = lk_vaddr;
    end

    // Register the lookup outcome one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_q <= xlat_en ? match_res : bypass_res;
            end
        end
    end

    // Drive the result ports from the registered outcome
    always_comb begin
        res_hit        = res_q.hit;
        res_miss       = res_q.miss;
        res_multi      = res_q.multi;
        res_paddr      = res_q.paddr;
        res_big_endian = res_q.be;
        res_elsz       = res_q.elsz;
        res_mixed      = res_q.mixed;
    end

    assign revision = {4'(REV_MAJOR), 4'(REV_MINOR)};

endmodule

// File: rtl/xlat_checker.sv
// Temporal checks on the translation buffer ports, bound into every instance.
module xlat_checker
    import xlat_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       cfg_wr_en,
    input logic [2:0] cfg_wr_sel,
    input logic       res_valid,
    input logic       res_hit,
    input logic       res_miss,
    input logic       res_multi,
    input logic [4:0] irq_status,
    input logic [4:0] irq_enable,
    input logic       xlat_en
);

    assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_outcome_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_multi}));

    assert_status_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && (cfg_wr_sel == SEL_STATUS))
        |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

    assert_fault_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_multi && $past(irq_enable[ST_MULTI])) |-> !xlat_en);

    assert_bypass_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !xlat_en) |=> (!res_hit && !res_miss && !res_multi));

endmodule

bind xlat_buffer xlat_checker i_xlat_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_sel (cfg_wr_sel),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_miss   (res_miss),
    .res_multi  (res_multi),
    .irq_status (irq_status),
    .irq_enable (irq_enable),
    .xlat_en    (xlat_en)
);

// File: tb/test_xlat_buffer.sv
// Self-checking bench: seeded random lookups and writes mixed with directed
// corner cases, compared against a behavioural model held in the bench.
module test_xlat_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int NE         = 8;
    localparam int WATCHDOG   = 50000;

    localparam bit [2:0] W_TAG = 0, W_DATA = 1, W_LOCK = 2, W_VIC = 3;
    localparam bit [2:0] W_EN = 4, W_CLR = 5, W_CTRL = 6, W_FLUSH = 7;
    localparam bit [31:0] KEEP_T = 32'hFFFF_F00F;
    localparam bit [31:0] KEEP_D = 32'hFFFF_F3C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        evt_walk = 1'b0, evt_emu = 1'b0, evt_xlat = 1'b0;
    logic        res_valid, res_hit, res_miss, res_multi;
    logic [31:0] res_paddr, rd_tag, rd_data, fault_addr;
    logic        res_big_endian, res_mixed, xlat_en, irq;
    logic [1:0]  res_elsz;
    logic [2:0]  lock_base, victim_idx;
    logic [4:0]  irq_status, irq_enable;
    logic [7:0]  revision;

    int n_chk = 0;
    int n_fail = 0;

    bit [31:0] mtag [NE];
    bit [31:0] mdata [NE];
    bit [31:0] mpend;
    bit [2:0]  mvic, mlock;
    bit [4:0]  mst, men;
    bit        mxen;
    bit [31:0] mfa;

    always #(CLK_PERIOD / 2) clk = ~clk;

    xlat_buffer i_xlat_buffer (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .evt_walk(evt_walk), .evt_emu(evt_emu), .evt_xlat(evt_xlat),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_multi(res_multi), .res_paddr(res_paddr), .res_big_endian(res_big_endian),
        .res_elsz(res_elsz), .res_mixed(res_mixed), .rd_tag(rd_tag), .rd_data(rd_data),
        .lock_base(lock_base), .victim_idx(victim_idx), .irq_status(irq_status),
        .irq_enable(irq_enable), .fault_addr(fault_addr), .xlat_en(xlat_en),
        .irq(irq), .revision(revision)
    );

    function automatic bit [31:0] bmask(input bit [1:0] p);
        case (p)
            2'd0:    return 32'hFFFF_F000;
            2'd1:    return 32'hFFFF_0000;
            2'd2:    return 32'hFFF0_0000;
            default: return 32'hFF00_0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: drive, update the model, sample at the next falling edge
    task automatic step(input bit lk, input bit [31:0] va, input bit we,
                        input bit [2:0] sel, input bit [31:0] wd,
                        input bit [2:0] ev, input string req);
        int        cnt = 0;
        bit [31:0] pa = 0, dsel = 0, msel = 0;
        bit [38:0] exp_res;
        bit [4:0]  setv = 0, clrv = 0;
        bit        fault;
        lk_valid = lk; lk_vaddr = va; cfg_wr_en = we; cfg_wr_sel = sel;
        cfg_wr_data = wd; {evt_walk, evt_emu, evt_xlat} = ev;
        for (int e = 0; e < NE; e++) begin
            if (mtag[e][2] && (((va ^ mtag[e]) & bmask(mtag[e][1:0])) == 0)) begin
                cnt++; dsel = mdata[e]; msel = bmask(mtag[e][1:0]);
            end
        end
        if (!mxen) exp_res = {3'b000, va, 4'b0};
        else if (cnt == 1) begin
            pa = (dsel & msel) | (va & ~msel);
            exp_res = {3'b100, pa, dsel[9], dsel[8:7], dsel[6]};
        end else if (cnt == 0) exp_res = {3'b010, 36'b0};
        else exp_res = {3'b001, 36'b0};
        if (lk && mxen) begin
            setv[0] = (cnt == 0);
            setv[4] = (cnt > 1);
        end
        setv[1] = ev[0]; setv[2] = ev[1]; setv[3] = ev[2];
        fault = (setv[0] && men[0]) || (setv[4] && men[4]);
        if (we) begin
            case (sel)
                W_TAG:  mpend = (wd & KEEP_T) | 32'h4;
                W_DATA: begin
                    mtag[mvic] = mpend; mdata[mvic] = wd & KEEP_D;
                    mvic = (mvic == 3'(NE - 1)) ? mlock : mvic + 1;
                end
                W_LOCK: mlock = wd[2:0];
                W_VIC:  mvic = wd[2:0];
                W_EN:   men = wd[4:0];
                W_CLR:  clrv = wd[4:0];
                W_CTRL: if (!fault) mxen = wd[0];
                default: for (int e = 0; e < NE; e++) if (!mtag[e][3]) mtag[e][2] = 1'b0;
            endcase
        end
        mst = (mst & ~clrv) | setv;
        if (fault) begin mfa = va; mxen = 1'b0; end
        @(negedge clk);
        lk_valid = 0; cfg_wr_en = 0; {evt_walk, evt_emu, evt_xlat} = 3'b0;
        if (lk) begin
            chk({req, " result"}, 64'({res_hit, res_miss, res_multi, res_paddr,
                res_big_endian, res_elsz, res_mixed}), 64'(exp_res));
            chk({req, " R3 res_valid"}, 64'(res_valid), 64'd1);
        end
        chk({req, " R9 R10 status/enable/irq"}, 64'({irq_status, irq_enable, xlat_en, irq}),
            64'({mst, men, mxen, |(mst & men)}));
        chk({req, " R7 fault_addr"}, 64'(fault_addr), 64'(mfa));
        chk({req, " R2 indices"}, 64'({lock_base, victim_idx}), 64'({mlock, mvic}));
    endtask

    task automatic wr(input bit [2:0] sel, input bit [31:0] wd, input string req);
        step(1'b0, 32'h0, 1'b1, sel, wd, 3'b0, req);
    endtask

    task automatic lookup(input bit [31:0] va, input string req);
        step(1'b1, va, 1'b0, 3'd0, 32'h0, 3'b0, req);
    endtask

    // Store one slot; garbage in unused bits checks the field masking (R1)
    task automatic load(input bit [31:0] va, input bit [1:0] psz, input bit prsv,
                        input bit [31:0] pa);
        wr(W_TAG, (va & bmask(psz)) | 32'h0000_0FF0 | (32'(prsv) << 3) | 32'(psz), "R1 tag");
        wr(W_DATA, pa | 32'h0000_0C3F, "R1 R2 data");
    endtask

    function automatic bit [31:0] in_slot(input int e);
        bit [31:0] m = bmask(mtag[e][1:0]);
        return (mtag[e] & m) | ($urandom & ~m);
    endfunction

    task automatic readback_all(input string req);
        for (int v = 0; v < NE; v++) begin
            wr(W_VIC, 32'(v), req);
            chk({req, " R1 rd_tag"}, 64'(rd_tag), 64'(mtag[v]));
            chk({req, " R1 rd_data"}, 64'(rd_data), 64'(mdata[v]));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int e = 0; e < NE; e++) begin mtag[e] = 0; mdata[e] = 0; end
        mpend = 0; mvic = 0; mlock = 0; mst = 0; men = 0; mxen = 0; mfa = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state, R12: revision
        chk("R13 reset outputs", 64'({res_valid, irq_status, irq_enable, xlat_en, irq,
            lock_base, victim_idx}), 64'd0);
        chk("R13 reset slot", 64'({rd_tag, rd_data}), 64'd0);
        chk("R13 reset fault_addr", 64'(fault_addr), 64'd0);
        chk("R12 revision", 64'(revision), 64'h12);

        wr(W_EN, 32'h1E, "R10 enable");
        load(32'h0100_0000 | $urandom, 2'($urandom), 1'b1, $urandom);
        load(32'h0200_0000 | ($urandom & 32'h00FF_FFFF), 2'($urandom), 1'b1, $urandom);
        wr(W_LOCK, 32'd2, "R2 lock");
        wr(W_VIC, 32'd2, "R2 victim");
        for (int e = 2; e < NE; e++)
            load((32'(e + 1) << 24) | ($urandom & 32'h00FF_FFFF), 2'(e), 1'b0, $urandom);
        chk("R2 wrap to lock base", 64'(victim_idx), 64'd2);
        readback_all("R1 readback");

        // R8: translation still off, lookups pass through
        lookup(in_slot(3), "R8 bypass before enable");
        wr(W_CTRL, 32'd1, "R9 ctrl on");

        // R3 R4 R5 R6 R9: random lookups, some paired with status clears
        for (int i = 0; i < 400; i++) begin
            bit [31:0] va = ($urandom_range(0, 4) == 0) ? (32'h8000_0000 | $urandom)
                                                        : in_slot($urandom_range(0, NE - 1));
            bit do_clr = ($urandom_range(0, 7) == 0);
            step(1'b1, va, do_clr, W_CLR, 32'($urandom), 3'($urandom_range(0, 7) == 0 ? 3'($urandom) : 3'b0),
                 "R3 R4 R5 random");
        end

        // R9: miss sets bit 0 in the same cycle software clears it: set wins
        step(1'b1, 32'hF000_0000, 1'b1, W_CLR, 32'h01, 3'b0, "R9 set beats clear");
        chk("R9 bit0 still set", 64'(irq_status[0]), 64'd1);
        wr(W_CLR, 32'h1F, "R9 clear all");
        chk("R9 cleared", 64'(irq_status), 64'd0);
        step(1'b0, 32'h0, 1'b0, 3'd0, 32'h0, 3'b111, "R10 events");
        chk("R10 irq from events", 64'({irq, irq_status}), 64'({1'b1, 5'b01110}));
        wr(W_CLR, 32'h1F, "R9 clear events");

        // R6 R7: overlapping 16 MB slot over slot 2's region gives a multi-hit fault
        wr(W_VIC, 32'd7, "R2 victim");
        load(32'h0300_0000, 2'd3, 1'b0, 32'h7700_0000);
        step(1'b1, in_slot(2), 1'b1, W_CTRL, 32'd1, 3'b0, "R6 R7 multi-hit");
        chk("R7 translation off", 64'(xlat_en), 64'd0);
        lookup(in_slot(0), "R8 bypass after fault");
        wr(W_CTRL, 32'd1, "R9 ctrl on");

        // R7: a miss faults only when its enable bit is set
        lookup(32'hE123_4567, "R5 R7 miss not enabled");
        wr(W_EN, 32'h1F, "R10 enable");
        lookup(32'hE765_4321, "R5 R7 miss enabled");
        chk("R7 fault address", 64'(fault_addr), 64'hE765_4321);
        wr(W_EN, 32'h1E, "R10 enable");
        wr(W_CTRL, 32'd1, "R9 ctrl on");

        // R11: flush keeps preserved slots
        wr(W_FLUSH, 32'd0, "R11 flush");
        lookup(in_slot(0), "R11 preserved hits");
        lookup(in_slot(1), "R11 preserved hits");
        lookup((mtag[4] & 32'hFF00_0000) | ($urandom & 32'h00FF_FFFF), "R11 flushed misses");
        readback_all("R11 readback");
        for (int i = 0; i < 60; i++)
            lookup(($urandom_range(0, 1) == 0) ? in_slot($urandom_range(0, 1))
                                               : (32'(($urandom_range(0, 7)) + 1) << 24) | ($urandom & 32'h00FF_FFFF),
                   "R4 R11 random after flush");
        finish_run();
    end

endmodule